// File: doc/BRIEF.md
# Video Memory Read/Write Bank Selector

This block produces the base addresses used by a banked video memory window. The window is 64 KB wide. Two 8-bit bank registers hold the current page numbers, one for host writes and one for host reads. Each bank base is the low five bits of its register shifted up by sixteen. A control register picks the mode. In dual mode the read base follows its own register. In single mode it mirrors the write base.

Each bank register can be loaded in two ways:
- Through an indexed extension register. The block stores the written byte with bit 1 inverted and keeps its low four bits.
- Through a direct port. This path is honoured only while a gate bit in the control register is set.

The block also tracks the memory-map field of a graphics mode register. From it, it derives the mask of the banked window, which widens to 128 KB when that field is cleared from a nonzero value. Both bank registers are returned at the ports so software readback can be served from them.

Top module: `vbank_selector`

## Requirements
- R1: After reset both bank registers read 0x00, both bases are 0, the aperture mask is 0x0FFFF and the mode field is 0.
- R2: `wr_base` equals `wr_bank[4:0]` times 65536; bits 7:5 of the register have no effect on it.
- R3: When control bit 0 is 1 (dual mode), `rd_base` equals `rd_bank[4:0]` times 65536; when it is 0, `rd_base` equals `wr_base`.
- R4: A write on the graphics index path to index 0xE loads `rd_bank` with `(data ^ 0x02) & 0x0F`.
- R5: A write on the sequencer index path to index 0xE loads `wr_bank` with `(data ^ 0x02) & 0x0F`.
- R6: A direct-port write (`dp_sel` 0 selects the write bank, 1 the read bank) loads the full byte only while control bit 2 is 1; otherwise the register keeps its value.
- R7: Graphics index 0xF writes the control register; indices other than 0x6, 0xE and 0xF change nothing.
- R8: Graphics index 0x6 sets the mode field to `data[3:2]`. The aperture mask then becomes 0x0FFFF for 01 and 0x07FFF for 10 or 11. For 00 it becomes 0x1FFFF if the previous field was nonzero, and is otherwise left as it was.
- R9: A register write is visible at the outputs after the clock edge that takes it and not before.
- R10: When an indexed write and a direct-port write target the same bank register in one cycle, the indexed value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gc_we | input | 1 | Graphics extension write strobe |
| gc_index | input | 4 | Graphics extension index |
| gc_wdata | input | 8 | Graphics extension write data |
| seq_we | input | 1 | Sequencer extension write strobe |
| seq_index | input | 4 | Sequencer extension index |
| seq_wdata | input | 8 | Sequencer extension write data |
| dp_we | input | 1 | Direct bank port write strobe |
| dp_sel | input | 1 | Direct port select: 0 write bank, 1 read bank |
| dp_wdata | input | 8 | Direct port write data |
| wr_base | output | 21 | Write bank base address |
| rd_base | output | 21 | Read bank base address |
| wr_bank | output | 8 | Write bank register readback |
| rd_bank | output | 8 | Read bank register readback |
| aperture_mask | output | 17 | Banked window address mask |

## Verification
A wrong bank register shows one cycle after the faulty write: its readback port, and in most modes a base output, carries the wrong page. A wrong control bit shows in two places. A bad dual bit makes `rd_base` split from or collapse onto `wr_base` at once. A bad gate bit only shows at the next direct-port write, which then lands or is lost. A wrong remembered mode field stays hidden until the field is next cleared, when the mask widens when it should not, or fails to widen. The bench therefore walks mode sequences that reach 00 both from a nonzero field and from 00.

// File: rtl/vbank_pkg.sv
package vbank_pkg;

  localparam logic [3:0] GC_IDX_MODE   = 4'h6;
  localparam logic [3:0] GC_IDX_RDBANK = 4'hE;
  localparam logic [3:0] GC_IDX_CTRL   = 4'hF;
  localparam logic [3:0] SQ_IDX_WRBANK = 4'hE;

  localparam int CTRL_DUAL_BIT   = 0;
  localparam int CTRL_DIRECT_BIT = 2;

  localparam logic [7:0] EXT_FLIP = 8'h02;
  localparam int         EXT_KEEP = 4;

  typedef enum logic [1:0] {
    MAP_WIDE  = 2'd0,
    MAP_64K   = 2'd1,
    MAP_32K_A = 2'd2,
    MAP_32K_B = 2'd3
  } map_mode_e;

  // Indexed extension fold: flip one bit, keep the low nibble.
  function automatic logic [7:0] ext_fold(input logic [7:0] v);
    logic [7:0] f;
    f = v ^ EXT_FLIP;
    return {{(8 - EXT_KEEP){1'b0}}, f[EXT_KEEP-1:0]};
  endfunction

endpackage

// File: rtl/vbank_regs.sv
module vbank_regs
  import vbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_we,
  input  logic [3:0]        gc_index,
  input  logic [DATA_W-1:0] gc_wdata,
  input  logic              seq_we,
  input  logic [3:0]        seq_index,
  input  logic [DATA_W-1:0] seq_wdata,
  input  logic              dp_we,
  input  logic              dp_sel,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [DATA_W-1:0] wr_bank_q,
  output logic [DATA_W-1:0] rd_bank_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              rd_ext_hit,
  output logic              wr_ext_hit,
  output logic              rd_dp_hit,
  output logic              wr_dp_hit
);

  logic ctrl_hit;
  logic gate_open;

  assign gate_open  = ctrl_q[CTRL_DIRECT_BIT];
  assign ctrl_hit   = gc_we  && (gc_index  == GC_IDX_CTRL);
  assign rd_ext_hit = gc_we  && (gc_index  == GC_IDX_RDBANK);
  assign wr_ext_hit = seq_we && (seq_index == SQ_IDX_WRBANK);
  assign rd_dp_hit  = dp_we  &&  dp_sel && gate_open;
  assign wr_dp_hit  = dp_we  && !dp_sel && gate_open;

  logic [DATA_W-1:0] wr_next, rd_next, ctrl_next;

  always_comb begin
    wr_next = wr_bank_q;
    if (wr_ext_hit)     wr_next = ext_fold(seq_wdata);
    else if (wr_dp_hit) wr_next = dp_wdata;
  end

  always_comb begin
    rd_next = rd_bank_q;
    if (rd_ext_hit)     rd_next = ext_fold(gc_wdata);
    else if (rd_dp_hit) rd_next = dp_wdata;
  end

  always_comb begin
    ctrl_next = ctrl_q;
    if (ctrl_hit) ctrl_next = gc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank_q <= '0;
      rd_bank_q <= '0;
      ctrl_q    <= '0;
    end else begin
      wr_bank_q <= wr_next;
      rd_bank_q <= rd_next;
      ctrl_q    <= ctrl_next;
    end
  end

endmodule

// File: rtl/vbank_base_calc.sv
module vbank_base_calc #(
  parameter int DATA_W     = 8,
  parameter int BANK_BITS  = 5,
  parameter int BANK_SHIFT = 16,
  localparam int ADDR_W    = BANK_BITS + BANK_SHIFT
) (
  input  logic [DATA_W-1:0] bank,
  output logic [ADDR_W-1:0] base
);

  function automatic logic [ADDR_W-1:0] page_base(input logic [DATA_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[ADDR_W-1:BANK_SHIFT] = b[BANK_BITS-1:0];
    return r;
  endfunction

  assign base = page_base(bank);

endmodule

// File: rtl/vbank_aperture.sv
module vbank_aperture
  import vbank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_SHIFT = 16,
  localparam int MASK_W    = BANK_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_we,
  input  logic [3:0]        gc_index,
  input  logic [DATA_W-1:0] gc_wdata,
  output logic [MASK_W-1:0] mask_q,
  output map_mode_e         mode_q,
  output logic              widen_evt
);

  localparam logic [MASK_W-1:0] MASK_WIDE = {MASK_W{1'b1}};
  localparam logic [MASK_W-1:0] MASK_64K  = {1'b0, {BANK_SHIFT{1'b1}}};
  localparam logic [MASK_W-1:0] MASK_32K  = {2'b00, {(BANK_SHIFT-1){1'b1}}};

  logic      mode_hit;
  map_mode_e mode_new;

  assign mode_hit  = gc_we && (gc_index == GC_IDX_MODE);
  assign mode_new  = map_mode_e'(gc_wdata[3:2]);
  assign widen_evt = mode_hit && (mode_new == MAP_WIDE) && (mode_q != MAP_WIDE);

  function automatic logic [MASK_W-1:0] next_mask(input map_mode_e nm,
                                                  input logic widen,
                                                  input logic [MASK_W-1:0] cur);
    case (nm)
      MAP_WIDE: return widen ? MASK_WIDE : cur;
      MAP_64K:  return MASK_64K;
      default:  return MASK_32K;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_64K;
      mode_q <= MAP_WIDE;
    end else if (mode_hit) begin
      mask_q <= next_mask(mode_new, widen_evt, mask_q);
      mode_q <= mode_new;
    end
  end

endmodule

// File: rtl/vbank_selector.sv
module vbank_selector
  import vbank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BITS  = 5,
  parameter int BANK_SHIFT = 16,
  localparam int ADDR_W    = BANK_BITS + BANK_SHIFT,
  localparam int MASK_W    = BANK_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_we,
  input  logic [3:0]        gc_index,
  input  logic [DATA_W-1:0] gc_wdata,
  input  logic              seq_we,
  input  logic [3:0]        seq_index,
  input  logic [DATA_W-1:0] seq_wdata,
  input  logic              dp_we,
  input  logic              dp_sel,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] rd_base,
  output logic [DATA_W-1:0] wr_bank,
  output logic [DATA_W-1:0] rd_bank,
  output logic [MASK_W-1:0] aperture_mask
);

  logic [DATA_W-1:0] ctrl_q;
  logic              rd_ext_hit, wr_ext_hit, rd_dp_hit, wr_dp_hit;
  logic              widen_evt;
  map_mode_e         mode_q;
  logic              dual_mode;
  logic [ADDR_W-1:0] base_of [2];
  logic [DATA_W-1:0] bank_of [2];

  vbank_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .gc_we      (gc_we),
    .gc_index   (gc_index),
    .gc_wdata   (gc_wdata),
    .seq_we     (seq_we),
    .seq_index  (seq_index),
    .seq_wdata  (seq_wdata),
    .dp_we      (dp_we),
    .dp_sel     (dp_sel),
    .dp_wdata   (dp_wdata),
    .wr_bank_q  (wr_bank),
    .rd_bank_q  (rd_bank),
    .ctrl_q     (ctrl_q),
    .rd_ext_hit (rd_ext_hit),
    .wr_ext_hit (wr_ext_hit),
    .rd_dp_hit  (rd_dp_hit),
    .wr_dp_hit  (wr_dp_hit)
  );

  assign bank_of[0] = wr_bank;
  assign bank_of[1] = rd_bank;

  for (genvar g = 0; g < 2; g++) begin : g_base
    vbank_base_calc #(
      .DATA_W    (DATA_W),
      .BANK_BITS (BANK_BITS),
      .BANK_SHIFT(BANK_SHIFT)
    ) u_calc (
      .bank (bank_of[g]),
      .base (base_of[g])
    );
  end

  assign dual_mode = ctrl_q[CTRL_DUAL_BIT];
  assign wr_base   = base_of[0];
  assign rd_base   = dual_mode ? base_of[1] : base_of[0];

  vbank_aperture #(
    .DATA_W    (DATA_W),
    .BANK_SHIFT(BANK_SHIFT)
  ) u_ap (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_we     (gc_we),
    .gc_index  (gc_index),
    .gc_wdata  (gc_wdata),
    .mask_q    (aperture_mask),
    .mode_q    (mode_q),
    .widen_evt (widen_evt)
  );

endmodule

// File: rtl/vbank_selector_chk.sv
module vbank_selector_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 21,
  parameter int MASK_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gc_we,
  input logic [3:0]        gc_index,
  input logic [DATA_W-1:0] gc_wdata,
  input logic              seq_we,
  input logic [3:0]        seq_index,
  input logic [DATA_W-1:0] seq_wdata,
  input logic              dp_we,
  input logic              dp_sel,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [ADDR_W-1:0] wr_base,
  input logic [ADDR_W-1:0] rd_base,
  input logic [DATA_W-1:0] wr_bank,
  input logic [DATA_W-1:0] rd_bank,
  input logic [MASK_W-1:0] aperture_mask,
  input logic              widen_evt
);

  assert_write_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base[15:0] == 16'h0) && (wr_base[20:16] == wr_bank[4:0]));

  assert_single_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (rd_base == wr_base));

  assert_ext_fold_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_we && gc_index == 4'hE) |=> (rd_bank == (($past(gc_wdata) ^ 8'h02) & 8'h0F)));

  assert_ext_fold_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && seq_index == 4'hE) |=> (wr_bank == (($past(seq_wdata) ^ 8'h02) & 8'h0F)));

  assert_gate_blocks_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && !dp_sel && !ctrl_q[2] && !(seq_we && seq_index == 4'hE)) |=> $stable(wr_bank));

  assert_gate_blocks_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && dp_sel && !ctrl_q[2] && !(gc_we && gc_index == 4'hE)) |=> $stable(rd_bank));

  assert_widen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    widen_evt |=> (aperture_mask == 17'h1FFFF));

endmodule

bind vbank_selector vbank_selector_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gc_we         (gc_we),
  .gc_index      (gc_index),
  .gc_wdata      (gc_wdata),
  .seq_we        (seq_we),
  .seq_index     (seq_index),
  .seq_wdata     (seq_wdata),
  .dp_we         (dp_we),
  .dp_sel        (dp_sel),
  .ctrl_q        (ctrl_q),
  .wr_base       (wr_base),
  .rd_base       (rd_base),
  .wr_bank       (wr_bank),
  .rd_bank       (rd_bank),
  .aperture_mask (aperture_mask),
  .widen_evt     (widen_evt)
);

// File: tb/vbank_selector_test.sv
module vbank_selector_test;

  localparam int PERIOD = 10;
  localparam int NVEC   = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gc_we = 1'b0, seq_we = 1'b0, dp_we = 1'b0, dp_sel = 1'b0;
  logic [3:0]  gc_index = '0, seq_index = '0;
  logic [7:0]  gc_wdata = '0, seq_wdata = '0, dp_wdata = '0;
  logic [20:0] wr_base, rd_base;
  logic [7:0]  wr_bank, rd_bank;
  logic [16:0] aperture_mask;

  int total = 0;
  int fails = 0;
  logic exp_dual = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  vbank_selector uut (
    .clk(clk), .rst_n(rst_n),
    .gc_we(gc_we), .gc_index(gc_index), .gc_wdata(gc_wdata),
    .seq_we(seq_we), .seq_index(seq_index), .seq_wdata(seq_wdata),
    .dp_we(dp_we), .dp_sel(dp_sel), .dp_wdata(dp_wdata),
    .wr_base(wr_base), .rd_base(rd_base),
    .wr_bank(wr_bank), .rd_bank(rd_bank),
    .aperture_mask(aperture_mask)
  );

  // op: 0 graphics index, 1 sequencer index, 2 direct port (idx[0] = select)
  // fields: op, idx, data, expected wr_bank, expected rd_bank, expected mask
  localparam logic [46:0] VEC [NVEC] = '{
    {2'd2, 4'd0, 8'h1A, 8'h00, 8'h00, 17'h0FFFF}, // R6 gate closed
    {2'd0, 4'hF, 8'h05, 8'h00, 8'h00, 17'h0FFFF}, // R7 dual + gate
    {2'd2, 4'd0, 8'hE7, 8'hE7, 8'h00, 17'h0FFFF}, // R6 R2 upper bits ignored
    {2'd2, 4'd1, 8'h13, 8'hE7, 8'h13, 17'h0FFFF}, // R6 R3 dual
    {2'd0, 4'hE, 8'h0B, 8'hE7, 8'h09, 17'h0FFFF}, // R4
    {2'd1, 4'hE, 8'h02, 8'h00, 8'h09, 17'h0FFFF}, // R5
    {2'd1, 4'hE, 8'hFD, 8'h0F, 8'h09, 17'h0FFFF}, // R5
    {2'd0, 4'hF, 8'h04, 8'h0F, 8'h09, 17'h0FFFF}, // R3 single
    {2'd2, 4'd1, 8'h1F, 8'h0F, 8'h1F, 17'h0FFFF}, // R3 mirror holds
    {2'd0, 4'hF, 8'h00, 8'h0F, 8'h1F, 17'h0FFFF}, // R7 gate off
    {2'd2, 4'd0, 8'h55, 8'h0F, 8'h1F, 17'h0FFFF}, // R6 ignored
    {2'd0, 4'h6, 8'h04, 8'h0F, 8'h1F, 17'h0FFFF}, // R8 64K
    {2'd0, 4'h6, 8'h08, 8'h0F, 8'h1F, 17'h07FFF}, // R8 32K
    {2'd0, 4'h6, 8'h00, 8'h0F, 8'h1F, 17'h1FFFF}, // R8 widen
    {2'd0, 4'h6, 8'h01, 8'h0F, 8'h1F, 17'h1FFFF}, // R8 00 from 00 keeps
    {2'd0, 4'h6, 8'h0C, 8'h0F, 8'h1F, 17'h07FFF}, // R8 32K
    {2'd0, 4'h6, 8'h00, 8'h0F, 8'h1F, 17'h1FFFF}, // R8 widen again
    {2'd0, 4'h5, 8'hFF, 8'h0F, 8'h1F, 17'h1FFFF}  // R7 other index
  };

  function automatic logic [20:0] page_addr(input logic [7:0] b);
    return {b[4:0], 16'h0000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] idx, input logic [7:0] d);
    case (op)
      2'd0: begin gc_we = 1'b1; gc_index = idx; gc_wdata = d; end
      2'd1: begin seq_we = 1'b1; seq_index = idx; seq_wdata = d; end
      default: begin dp_we = 1'b1; dp_sel = idx[0]; dp_wdata = d; end
    endcase
  endtask

  task automatic idle();
    gc_we = 1'b0; seq_we = 1'b0; dp_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(PERIOD * 5000);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wr_bank", wr_bank, 0);
    check("R1 rd_bank", rd_bank, 0);
    check("R1 wr_base", wr_base, 0);
    check("R1 rd_base", rd_base, 0);
    check("R1 mask", aperture_mask, 32'h0FFFF);

    for (int i = 0; i < NVEC; i++) begin
      logic [46:0] v;
      v = VEC[i];
      drive(v[46:45], v[44:41], v[40:33]);
      if (v[46:45] == 2'd0 && v[44:41] == 4'hF) exp_dual = v[33];
      @(negedge clk);
      idle();
      check("R4 R5 R6 R7 wr_bank", wr_bank, v[32:25]);
      check("R4 R5 R6 R7 rd_bank", rd_bank, v[24:17]);
      check("R8 mask", aperture_mask, v[16:0]);
      check("R2 wr_base", wr_base, page_addr(v[32:25]));
      check("R3 rd_base", rd_base, exp_dual ? page_addr(v[24:17]) : page_addr(v[32:25]));
    end

    // R9: new value not visible before the edge, visible after it
    drive(2'd0, 4'hF, 8'h05);
    @(negedge clk);
    idle();
    drive(2'd2, 4'd0, 8'h03);
    #1;
    check("R9 before edge", wr_bank, 32'h0F);
    @(negedge clk);
    idle();
    check("R9 after edge", wr_bank, 32'h03);
    check("R9 wr_base", wr_base, 32'h30000);

    // R10: indexed and direct writes to the same register in one cycle
    drive(2'd0, 4'hE, 8'h03);
    drive(2'd2, 4'd1, 8'h77);
    @(negedge clk);
    idle();
    check("R10 rd_bank", rd_bank, 32'h01);
    check("R10 rd_base dual", rd_base, 32'h10000);
    drive(2'd1, 4'hE, 8'h06);
    drive(2'd2, 4'd0, 8'h88);
    @(negedge clk);
    idle();
    check("R10 wr_bank", wr_bank, 32'h04);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 wr_bank after reset", wr_bank, 0);
    check("R1 rd_bank after reset", rd_bank, 0);
    check("R1 mask after reset", aperture_mask, 32'h0FFFF);
    // R1: mode field back to 0, so clearing it does not widen
    drive(2'd0, 4'h6, 8'h00);
    @(negedge clk);
    idle();
    check("R1 R8 mode cleared by reset", aperture_mask, 32'h0FFFF);
    // R1: control cleared, so direct port is gated off
    drive(2'd2, 4'd1, 8'h12);
    @(negedge clk);
    idle();
    check("R1 R6 gate closed after reset", rd_bank, 0);

    finish_run();
  end

endmodule